// File: doc/BRIEF.md
# Single-Channel Bus-Request DMA Controller

This block moves a programmed number of words between a peripheral and memory without the processor handling each word. Software loads a start address, a word count and a mode word through a small chip-select/register-select port. Once the channel is enabled and the peripheral raises its request, the controller asks the processor for the system bus. When the bus is granted, it acknowledges the peripheral and drives the memory address and one strobe for each word. The word itself travels directly between the peripheral and memory on the shared data bus, so the controller only supplies the address and the strobe.

After each word the address steps up by one and the count steps down by one. When the count reaches zero the controller releases the bus and raises an end-of-transfer interrupt. The channel can hand the bus back after every word, so that the processor keeps running between words. It can also hold the bus and move words back to back for as long as the peripheral keeps its request raised.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, `br_o`, `dack_o`, `bus_oe_o`, `mem_rd_o`, `mem_wr_o` and `irq_o` are low. The address, count and control registers read as zero.
- R2: While `bg_i` is low, a cycle with `cs_i` and `wr_i` high loads `cpu_wdata_i` into the register chosen by `rs_i`. The codes are: 0 address, 1 word count, 2 control (bit 0 direction, bit 1 burst, bit 2 enable). A read with `cs_i` and `rd_i` high returns that register on `cpu_rdata_o`, zero-extended. Code 3 returns status, with bit 0 holding the interrupt flag.
- R3: When the channel is enabled, the count is non-zero and `dreq_i` is high, `br_o` rises on the next clock. No acknowledge and no strobe appear until `bg_i` has been seen high.
- R4: Each word occupies one clock cycle. In that cycle `dack_o` and `bus_oe_o` are high and `mem_addr_o` equals the address register. If direction is 0, `mem_wr_o` is high (peripheral to memory). If direction is 1, `mem_rd_o` is high (memory to peripheral). The two strobes are never high together.
- R5: After each word, the address register has increased by one and the count register has decreased by one.
- R6: The word that takes the count to zero sets the interrupt flag and drops `br_o`. No further word is moved while the count is zero, even with `dreq_i` held high.
- R7: With burst = 0 (cycle stealing), `br_o` falls after every word. A new request follows once `bg_i` has gone low, so an N-word job produces N rising edges of `br_o`.
- R8: With burst = 1, words follow on consecutive cycles under a single bus request while `dreq_i` stays high. If `dreq_i` is low at the end of a word, the bus is released, and the job resumes at the next request.
- R9: While `bg_i` is high, CPU reads return zero and CPU writes have no effect on any register.
- R10: Any CPU write to the control register clears the interrupt flag.
- R11: A request from the peripheral while the channel is disabled, or while the count is zero, leaves `br_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | CPU port select |
| rs_i | input | 2 | Register select code |
| rd_i | input | 1 | CPU read |
| wr_i | input | 1 | CPU write |
| cpu_wdata_i | input | DW | CPU write data |
| cpu_rdata_o | output | DW | CPU read data (zero when not selected or bus granted) |
| dreq_i | input | 1 | Peripheral transfer request |
| dack_o | output | 1 | Per-word acknowledge to the peripheral |
| br_o | output | 1 | Bus request to the processor |
| bg_i | input | 1 | Bus grant from the processor |
| bus_oe_o | output | 1 | Controller drives the address bus and strobes |
| mem_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| irq_o | output | 1 | End-of-transfer interrupt |

## Verification
The hardest case is a burst that the peripheral interrupts partway through. Its request must fall in exactly the cycle of a word so that the controller releases the bus with words still outstanding. The bench watches for the first acknowledge and drops the request at that same half-cycle. It then checks that exactly one word moved, that no interrupt was raised and that the count is one lower, before raising the request again to finish the job. The bus-grant model is a delayed copy of the request that can be held off, which lets the bench show that a pending request produces no strobe and lets it attempt CPU accesses while the grant is active.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER, ST_REL} dma_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_DIR   = 0;
  localparam int CTRL_BURST = 1;
  localparam int CTRL_EN    = 2;
  localparam int CTRL_W     = 3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [1:0]    sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bg_i,
  input  logic          word_done_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] addr_o,
  output logic          dir_o,
  output logic          burst_o,
  output logic          armed_o,
  output logic          last_o,
  output logic          irq_o
);
  logic [AW-1:0]     addr_q;
  logic [CW-1:0]     cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_q;
  logic              cpu_ok, we, ctrl_we;

  assign cpu_ok  = cs_i & ~bg_i;
  assign we      = cpu_ok & wr_i;
  assign ctrl_we = we & (sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else if (word_done_i) begin
      addr_q <= addr_q + AW'(1);
      cnt_q  <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) irq_q <= 1'b1;
    end else if (we) begin
      case (sel_i)
        SEL_ADDR: addr_q <= AW'(wdata_i);
        SEL_CNT:  cnt_q  <= CW'(wdata_i);
        SEL_CTRL: begin
          ctrl_q <= wdata_i[CTRL_W-1:0];
          irq_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cpu_ok && rd_i) begin
      case (sel_i)
        SEL_ADDR: rdata_o = DW'(addr_q);
        SEL_CNT:  rdata_o = DW'(cnt_q);
        SEL_CTRL: rdata_o = DW'(ctrl_q);
        default:  rdata_o = DW'(irq_q);
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign dir_o   = ctrl_q[CTRL_DIR];
  assign burst_o = ctrl_q[CTRL_BURST];
  assign armed_o = ctrl_q[CTRL_EN] & (cnt_q != '0);
  assign last_o  = (cnt_q == CW'(1));
  assign irq_o   = irq_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_i |=> cnt_q == $past(cnt_q) - CW'(1)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_i |=> addr_q == $past(addr_q) + AW'(1)); // R5
  AST_IRQ_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> cnt_q == '0); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(ctrl_we)); // R10
  AST_GRANT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bg_i && !word_done_i) |=> ($stable(addr_q) && $stable(cnt_q) && $stable(ctrl_q))); // R9
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic last_i,
  input  logic burst_i,
  input  logic dreq_i,
  input  logic bg_i,
  output logic br_o,
  output logic xfer_o
);
  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (armed_i && dreq_i) state_d = ST_REQ;
      ST_REQ:  if (bg_i) state_d = ST_XFER;
      ST_XFER: begin
        // keep the bus only in burst mode with more words wanted
        if (last_i || !burst_i || !dreq_i) state_d = ST_REL;
      end
      ST_REL:  if (!bg_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign br_o   = (state_q == ST_REQ) | (state_q == ST_XFER);
  assign xfer_o = (state_q == ST_XFER);

  AST_WAIT_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && !bg_i) |=> !xfer_o); // R3
  AST_NO_WORD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> armed_i); // R6
  AST_STEAL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !burst_i) |=> !br_o); // R7
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && burst_i && !last_i && dreq_i) |=> xfer_o); // R8
  AST_NO_REQ_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !armed_i) |=> !br_o); // R11
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [1:0]    rs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          dreq_i,
  output logic          dack_o,
  output logic          br_o,
  input  logic          bg_i,
  output logic          bus_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          irq_o
);
  logic [AW-1:0] addr;
  logic dir, burst, armed, last, xfer;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .cs_i, .sel_i(rs_i), .rd_i, .wr_i,
    .wdata_i(cpu_wdata_i), .bg_i, .word_done_i(xfer),
    .rdata_o(cpu_rdata_o), .addr_o(addr), .dir_o(dir), .burst_o(burst),
    .armed_o(armed), .last_o(last), .irq_o
  );

  dma_seq u_seq (
    .clk_i, .rst_ni, .armed_i(armed), .last_i(last), .burst_i(burst),
    .dreq_i, .bg_i, .br_o, .xfer_o(xfer)
  );

  assign dack_o     = xfer;
  assign bus_oe_o   = xfer;
  assign mem_addr_o = xfer ? addr : '0;
  assign mem_wr_o   = xfer & ~dir;
  assign mem_rd_o   = xfer & dir;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o})); // R4
  AST_STROBE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> (dack_o && br_o)); // R4
endmodule

// File: tb/dma_ctrl_bench.sv
module dma_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, CW = 16, DW = 16;

  logic clk = 0, rst_n = 0;
  logic cs = 0, rd = 0, wr = 0, dreq = 0, bg = 0;
  logic [1:0] rs = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic dack, br, oe, mrd, mwr, irq;
  logic [AW-1:0] maddr;
  logic grant_en = 0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_wr = 0, n_rd = 0, n_br = 0, bad_addr = 0, first_c = -1, last_c = -1;
  logic br_prev = 0;
  logic [AW-1:0] exp_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctrl #(.AW(AW), .CW(CW), .DW(DW)) u_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rs_i(rs), .rd_i(rd), .wr_i(wr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .dreq_i(dreq), .dack_o(dack),
    .br_o(br), .bg_i(bg), .bus_oe_o(oe), .mem_addr_o(maddr),
    .mem_rd_o(mrd), .mem_wr_o(mwr), .irq_o(irq)
  );

  // processor model: grant follows request one cycle later
  always @(posedge clk) bg <= br & grant_en;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (br && !br_prev) n_br <= n_br + 1;
    br_prev <= br;
    if (mwr || mrd) begin
      if (mwr) n_wr <= n_wr + 1;
      if (mrd) n_rd <= n_rd + 1;
      if (maddr != exp_addr || !dack || !oe) bad_addr <= bad_addr + 1;
      exp_addr <= exp_addr + 1;
      if (first_c < 0) first_c <= cyc;
      last_c <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon(input logic [AW-1:0] start);
    @(negedge clk);
    n_wr = 0; n_rd = 0; n_br = 0; bad_addr = 0; first_c = -1; last_c = -1;
    exp_addr = start;
  endtask

  task automatic cpu_wr(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cs = 1; wr = 1; rs = sel; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic cpu_rd(input logic [1:0] sel, output logic [DW-1:0] d);
    @(negedge clk);
    cs = 1; rd = 1; rs = sel;
    #1 d = rdata;
    cs = 0; rd = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk(!br && !dack && !oe && !mrd && !mwr && !irq, "R1 outputs", {br, dack, irq}, 0);
    cpu_rd(0, v); chk(v == 0, "R1 addr", v, 0);
    cpu_rd(1, v); chk(v == 0, "R1 count", v, 0);
    cpu_rd(2, v); chk(v == 0, "R1 ctrl", v, 0);
  endtask

  task automatic t_regs_disabled();
    logic [DW-1:0] v;
    cpu_wr(0, 16'h0100); cpu_wr(1, 16'd4); cpu_wr(2, 16'h0003);
    cpu_rd(0, v); chk(v == 16'h0100, "R2 addr readback", v, 16'h0100);
    cpu_rd(1, v); chk(v == 4, "R2 count readback", v, 4);
    cpu_rd(2, v); chk(v == 3, "R2 ctrl readback", v, 3);
    clr_mon(16'h0100);
    grant_en = 1; dreq = 1;
    repeat (6) @(negedge clk);
    chk(n_br == 0 && !br, "R11 disabled no request", n_br, 0);
    dreq = 0;
    cpu_wr(1, 16'd0); cpu_wr(2, 16'h0004);
    dreq = 1;
    repeat (6) @(negedge clk);
    chk(n_br == 0 && !br, "R11 zero count no request", n_br, 0);
    dreq = 0;
  endtask

  task automatic t_steal();
    logic [DW-1:0] v;
    grant_en = 0;
    cpu_wr(0, 16'h0100); cpu_wr(1, 16'd4);
    clr_mon(16'h0100);
    cpu_wr(2, 16'h0004);
    dreq = 1;
    @(negedge clk); @(negedge clk);
    chk(br == 1, "R3 br raised", br, 1);
    repeat (3) @(negedge clk);
    chk(!dack && n_wr == 0, "R3 no ack before grant", n_wr, 0);
    grant_en = 1;
    wait_irq();
    chk(n_wr == 4 && n_rd == 0, "R4 write strobes", n_wr, 4);
    chk(bad_addr == 0, "R4 address sequence", bad_addr, 0);
    chk(n_br == 4, "R7 request per word", n_br, 4);
    chk(irq == 1, "R6 irq raised", irq, 1);
    repeat (6) @(negedge clk);
    chk(n_wr == 4 && !br, "R6 stop at zero", n_wr, 4);
    dreq = 0;
    cpu_rd(0, v); chk(v == 16'h0104, "R5 addr advanced", v, 16'h0104);
    cpu_rd(1, v); chk(v == 0, "R5 count zero", v, 0);
    cpu_rd(3, v); chk(v == 1, "R2 status irq", v, 1);
    cpu_wr(2, 16'h0000);
    chk(irq == 0, "R10 irq cleared", irq, 0);
  endtask

  task automatic t_burst();
    logic [DW-1:0] v;
    cpu_wr(0, 16'h0200); cpu_wr(1, 16'd8);
    clr_mon(16'h0200);
    cpu_wr(2, 16'h0007);
    dreq = 1;
    for (int i = 0; i < 50 && !dack; i++) @(negedge clk);
    #1 cs = 1; rd = 1; rs = 0;
    #1 chk(rdata == 0, "R9 read blocked under grant", rdata, 0);
    rd = 0; wr = 1; wdata = 16'hAAAA;
    @(negedge clk);
    cs = 0; wr = 0;
    wait_irq();
    dreq = 0;
    chk(n_rd == 8 && n_wr == 0, "R4 read strobes", n_rd, 8);
    chk(bad_addr == 0, "R4 burst addresses", bad_addr, 0);
    chk(n_br == 1, "R8 single request", n_br, 1);
    chk(last_c - first_c == 7, "R8 back to back", last_c - first_c, 7);
    cpu_rd(0, v); chk(v == 16'h0208, "R9 write ignored under grant", v, 16'h0208);
    cpu_wr(2, 16'h0000);
  endtask

  task automatic t_burst_pause();
    logic [DW-1:0] v;
    cpu_wr(0, 16'h0300); cpu_wr(1, 16'd3);
    clr_mon(16'h0300);
    cpu_wr(2, 16'h0006);
    dreq = 1;
    for (int i = 0; i < 50 && !dack; i++) @(negedge clk);
    dreq = 0;
    repeat (6) @(negedge clk);
    chk(n_wr == 1 && !br, "R8 release on request low", n_wr, 1);
    chk(irq == 0, "R8 no irq mid job", irq, 0);
    cpu_rd(1, v); chk(v == 2, "R8 count after pause", v, 2);
    dreq = 1;
    wait_irq();
    dreq = 0;
    chk(n_wr == 3 && bad_addr == 0, "R8 resumed job", n_wr, 3);
    chk(n_br == 2, "R8 two requests", n_br, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs_disabled();
    t_steal();
    t_burst();
    t_burst_pause();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule